// File: doc/BRIEF.md
# Pin Function Router with Per-Path Overrides

This block sits between a bank of general-purpose pins and the peripherals that share them. Each pin holds a small configuration word. A 5-bit selector in that word picks which of up to ten peripheral functions owns the pin. The owning function drives the pin's output value and output enable. The pin's input value is sent back to the same function. Every function offers a fixed number of signal slots. A pin connects to slot `pin mod SLOTS` of its selected function, so several pins can reach the same peripheral signal.

Four independent 2-bit override stages sit on the output value, the output enable, the input toward the peripherals and the pin's interrupt line. Each stage can pass its signal, invert it, force it low or force it high. Selector codes that name no function, or that name a function the pin does not offer, leave the pin with a low output and an inactive enable before the override stage. Such a pin also feeds nothing back to any peripheral. Software reads and writes the configuration words through a simple port indexed by pin number.

Top module: `pin_route_mux`

## Requirements
- R1: After reset every selector reads 0x1F and every override field reads 0. Every pad_out and pad_oe is 0, and irq_out follows irq_raw.
- R2: A write with cfg_we high stores cfg_wdata for pin cfg_addr at the clock edge. cfg_rdata shows the addressed pin's word combinationally. The word layout is selector in bits 4:0, output override in 6:5, enable override in 8:7, input override in 10:9 and interrupt override in 12:11. Every field reads back exactly as written.
- R3: Writes to an address of NUM_PINS or above change no stored word. Reads from such an address return 0.
- R4: When pin p selects an available function f (code 0 to 9) with overrides 0, pad_out[p] equals fn_out[f*SLOTS + p mod SLOTS] and pad_oe[p] equals fn_oe at the same index.
- R5: Output and enable signals of functions a pin has not selected have no effect on that pin.
- R6: Selector code 0x1F, or any code from 10 to 30, gives a low output and an inactive enable before the overrides, and routes the pin's input to no peripheral.
- R7: Function 8 exists only on pins 20 to 25. Selecting it on any other pin behaves as in R6.
- R8: Output override codes act on the selected output value: 0 passes it, 1 inverts it, 2 forces 0 and 3 forces 1.
- R9: Enable override codes use the same encoding as R8 on the output enable. Code 2 disables the output and code 3 enables it.
- R10: The input override uses the same encoding as R8. It is applied to pad_in before the value reaches the selected function's input slot.
- R11: The interrupt override uses the same encoding as R8. It maps irq_raw[p] to irq_out[p], whatever the selector holds.
- R12: fn_in[f*SLOTS + s] is the OR of the overridden inputs of all pins p where p mod SLOTS = s and function f is selected and available on p.
- R13: A peripheral input slot that no pin routes to reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_PINS) | Pin index for reads and writes |
| cfg_wdata | input | 13 | Configuration word to write |
| cfg_rdata | output | 13 | Configuration word of the addressed pin |
| fn_out | input | NUM_FUNCS*SLOTS | Output values from the peripheral slots |
| fn_oe | input | NUM_FUNCS*SLOTS | Output enables from the peripheral slots |
| fn_in | output | NUM_FUNCS*SLOTS | Input values delivered to the peripheral slots |
| pad_in | input | NUM_PINS | Values sensed on the pins |
| pad_out | output | NUM_PINS | Output values toward the pins |
| pad_oe | output | NUM_PINS | Output enables toward the pins |
| irq_raw | input | NUM_PINS | Per-pin raw interrupt lines |
| irq_out | output | NUM_PINS | Per-pin interrupt lines after override |

## Verification
The hardest case to reach is one peripheral slot fed by several pins at once. The pins may carry different input overrides, and some of them may hold a function that is unavailable on that pin. In that case the OR must drop the invalid pins and still combine the valid ones. The stimulus programs four pins that share a slot to the same function. It then walks pad_in patterns in which exactly one pin, none of the pins, or two distant pins are high. Separate passes place the partially available function at the edges of its pin range and just outside it.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int SEL_W = 5;
  localparam int CFG_W = 13;
  localparam logic [SEL_W-1:0] SEL_NONE = 5'h1F;

  typedef enum logic [1:0] {
    OV_PASS = 2'd0,
    OV_INV  = 2'd1,
    OV_LOW  = 2'd2,
    OV_HIGH = 2'd3
  } ovr_e;

  typedef struct packed {
    ovr_e             irq_ov;
    ovr_e             in_ov;
    ovr_e             oe_ov;
    ovr_e             out_ov;
    logic [SEL_W-1:0] sel;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{irq_ov: OV_PASS, in_ov: OV_PASS,
                                     oe_ov: OV_PASS, out_ov: OV_PASS,
                                     sel: SEL_NONE};

  function automatic logic ovr_apply(ovr_e code, logic v);
    case (code)
      OV_PASS: return v;
      OV_INV:  return ~v;
      OV_LOW:  return 1'b0;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 30,
  localparam int AW = $clog2(NUM_PINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  pin_cfg_t                 wdata,
  output pin_cfg_t                 rdata,
  output pin_cfg_t [NUM_PINS-1:0]  cfg_q
);
  logic addr_ok;
  assign addr_ok = (int'(addr) < NUM_PINS);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                         cfg_q[i] <= CFG_RESET;
      else if (we && addr == AW'(i))      cfg_q[i] <= wdata;
    end

    assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == AW'(i)) |=> (cfg_q[i] == $past(wdata)));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (addr == AW'(i)) rdata = cfg_q[i];
  end

  assert_bad_addr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr_ok) |=> $stable(cfg_q));
endmodule

// File: rtl/pinmux_lane.sv
module pinmux_lane
  import pinmux_pkg::*;
#(
  parameter int          PIN       = 0,
  parameter int          NUM_FUNCS = 10,
  parameter logic [31:0] PART_MASK = 32'h100,
  parameter int          PART_LO   = 20,
  parameter int          PART_HI   = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pin_cfg_t             cfg,
  input  logic [NUM_FUNCS-1:0] col_out,
  input  logic [NUM_FUNCS-1:0] col_oe,
  input  logic                 pad_in,
  input  logic                 irq_raw,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 irq_out,
  output logic [NUM_FUNCS-1:0] route
);
  logic [NUM_FUNCS-1:0] fsel_oh;
  logic sel_ok, base_out, base_oe, in_ovr;

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
    localparam bit AV = !PART_MASK[f] || (PIN >= PART_LO && PIN <= PART_HI);
    assign fsel_oh[f] = AV && (cfg.sel == SEL_W'(f));
  end

  assign sel_ok   = |fsel_oh;
  assign base_out = |(fsel_oh & col_out);
  assign base_oe  = |(fsel_oh & col_oe);
  assign pad_out  = ovr_apply(cfg.out_ov, base_out);
  assign pad_oe   = ovr_apply(cfg.oe_ov, base_oe);
  assign in_ovr   = ovr_apply(cfg.in_ov, pad_in);
  assign route    = fsel_oh & {NUM_FUNCS{in_ovr}};
  assign irq_out  = ovr_apply(cfg.irq_ov, irq_raw);

  assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(route));
  assert_unselected_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && cfg.out_ov == OV_PASS && cfg.oe_ov == OV_PASS) |-> (!pad_out && !pad_oe && route == '0));
  assert_oe_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.oe_ov == OV_LOW) |-> !pad_oe);
  assert_irq_forced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.irq_ov == OV_HIGH) |-> irq_out);
endmodule

// File: rtl/pinmux_in_combine.sv
module pinmux_in_combine #(
  parameter int NUM_PINS  = 30,
  parameter int NUM_FUNCS = 10,
  parameter int SLOTS     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PINS*NUM_FUNCS-1:0] route_flat,
  output logic [NUM_FUNCS*SLOTS-1:0]    fn_in
);
  always_comb begin
    fn_in = '0;
    for (int p = 0; p < NUM_PINS; p++)
      for (int f = 0; f < NUM_FUNCS; f++)
        fn_in[f*SLOTS + (p % SLOTS)] = fn_in[f*SLOTS + (p % SLOTS)] | route_flat[p*NUM_FUNCS + f];
  end

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_idle
    logic any_route;
    always_comb begin
      any_route = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) any_route = any_route | route_flat[p*NUM_FUNCS + f];
    end
    assert_idle_slot_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !any_route |-> (fn_in[f*SLOTS +: SLOTS] == '0));
  end
endmodule

// File: rtl/pin_route_mux.sv
module pin_route_mux
  import pinmux_pkg::*;
#(
  parameter int          NUM_PINS  = 30,
  parameter int          NUM_FUNCS = 10,
  parameter int          SLOTS     = 8,
  parameter logic [31:0] PART_MASK = 32'h100,
  parameter int          PART_LO   = 20,
  parameter int          PART_HI   = 25
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [$clog2(NUM_PINS)-1:0]        cfg_addr,
  input  logic [12:0]                        cfg_wdata,
  output logic [12:0]                        cfg_rdata,
  input  logic [NUM_FUNCS*SLOTS-1:0]         fn_out,
  input  logic [NUM_FUNCS*SLOTS-1:0]         fn_oe,
  output logic [NUM_FUNCS*SLOTS-1:0]         fn_in,
  input  logic [NUM_PINS-1:0]                pad_in,
  output logic [NUM_PINS-1:0]                pad_out,
  output logic [NUM_PINS-1:0]                pad_oe,
  input  logic [NUM_PINS-1:0]                irq_raw,
  output logic [NUM_PINS-1:0]                irq_out
);
  pin_cfg_t [NUM_PINS-1:0]         cfg_q;
  pin_cfg_t                        rd_word;
  logic [NUM_PINS*NUM_FUNCS-1:0]   route_flat;

  pinmux_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(pin_cfg_t'(cfg_wdata)), .rdata(rd_word), .cfg_q(cfg_q)
  );
  assign cfg_rdata = rd_word;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_FUNCS-1:0] col_out, col_oe;
    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_col
      assign col_out[f] = fn_out[f*SLOTS + (p % SLOTS)];
      assign col_oe[f]  = fn_oe[f*SLOTS + (p % SLOTS)];
    end
    pinmux_lane #(
      .PIN(p), .NUM_FUNCS(NUM_FUNCS), .PART_MASK(PART_MASK),
      .PART_LO(PART_LO), .PART_HI(PART_HI)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[p]),
      .col_out(col_out), .col_oe(col_oe),
      .pad_in(pad_in[p]), .irq_raw(irq_raw[p]),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p]), .irq_out(irq_out[p]),
      .route(route_flat[p*NUM_FUNCS +: NUM_FUNCS])
    );
  end

  pinmux_in_combine #(.NUM_PINS(NUM_PINS), .NUM_FUNCS(NUM_FUNCS), .SLOTS(SLOTS)) u_comb (
    .clk(clk), .rst_n(rst_n), .route_flat(route_flat), .fn_in(fn_in)
  );
endmodule

// File: tb/sim_pin_route_mux.sv
module sim_pin_route_mux;
  localparam int NP = 30, NF = 10, NS = 8, AW = 5, CW = 13;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_wdata, cfg_rdata;
  logic [NF*NS-1:0] fn_out, fn_oe, fn_in;
  logic [NP-1:0] pad_in, pad_out, pad_oe, irq_raw, irq_out;

  pin_route_mux u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fn_out(fn_out), .fn_oe(fn_oe),
    .fn_in(fn_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_raw(irq_raw), .irq_out(irq_out)
  );

  logic [4:0] m_sel [NP];
  logic [1:0] m_oov [NP], m_eov [NP], m_iov [NP], m_qov [NP];

  typedef struct { string req; int kind; int idx; logic [31:0] exp; } item_t;
  item_t sbq[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic logic m_ovr(logic [1:0] c, logic v);
    case (c)
      2'd0: return v;
      2'd1: return ~v;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // function 8 only on pins 20..25 (R7); codes >= 10 own nothing (R6)
  function automatic bit m_avail(int f, int p);
    if (f >= NF) return 0;
    if (f == 8) return (p >= 20 && p <= 25);
    return 1;
  endfunction

  function automatic logic m_pad(int p, bit want_oe);
    logic b = 1'b0;
    int f = int'(m_sel[p]);
    if (m_avail(f, p)) b = want_oe ? fn_oe[f*NS + p%NS] : fn_out[f*NS + p%NS];
    return want_oe ? m_ovr(m_eov[p], b) : m_ovr(m_oov[p], b);
  endfunction

  function automatic logic m_fn_in(int idx);
    logic r = 1'b0;
    for (int p = 0; p < NP; p++)
      if (p % NS == idx % NS && int'(m_sel[p]) == idx / NS && m_avail(idx / NS, p))
        r = r | m_ovr(m_iov[p], pad_in[p]);
    return r;
  endfunction

  task automatic push(string req, int kind, int idx, logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.idx = idx; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic expect_all(string req);
    for (int p = 0; p < NP; p++) begin
      push(req, 0, p, 32'(m_pad(p, 0)));
      push(req, 1, p, 32'(m_pad(p, 1)));
      push(req, 3, p, 32'(m_ovr(m_qov[p], irq_raw[p])));
    end
    for (int i = 0; i < NF*NS; i++) push(req, 2, i, 32'(m_fn_in(i)));
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int addr, logic [4:0] sel, logic [1:0] oov, logic [1:0] eov,
                    logic [1:0] iov, logic [1:0] qov);
    step();
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = {qov, iov, eov, oov, sel};
    step();
    cfg_we = 1'b0;
    if (addr < NP) begin
      m_sel[addr] = sel; m_oov[addr] = oov; m_eov[addr] = eov;
      m_iov[addr] = iov; m_qov[addr] = qov;
    end
  endtask

  task automatic rd_check(string req, int addr);
    cfg_addr = AW'(addr);
    if (addr < NP) push(req, 4, addr, 32'({m_qov[addr], m_iov[addr], m_eov[addr], m_oov[addr], m_sel[addr]}));
    else           push(req, 4, addr, 32'd0);
    step();
  endtask

  task automatic rand_inputs();
    logic [95:0] t;
    t = {$urandom, $urandom, $urandom}; fn_out = t[NF*NS-1:0];
    t = {$urandom, $urandom, $urandom}; fn_oe  = t[NF*NS-1:0];
    pad_in  = NP'($urandom);
    irq_raw = NP'($urandom);
  endtask

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin : mon
    item_t it;
    logic [31:0] act;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.kind)
        0: act = 32'(pad_out[it.idx]);
        1: act = 32'(pad_oe[it.idx]);
        2: act = 32'(fn_in[it.idx]);
        3: act = 32'(irq_out[it.idx]);
        default: act = 32'(cfg_rdata);
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    fn_out = '1; fn_oe = '1; pad_in = '1; irq_raw = '0;
    for (int p = 0; p < NP; p++) begin
      m_sel[p] = 5'h1F; m_oov[p] = 0; m_eov[p] = 0; m_iov[p] = 0; m_qov[p] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R13: reset state, no slot routed
    expect_all("R1");
    rd_check("R1", 0);
    rd_check("R1", 29);
    irq_raw = NP'($urandom);
    expect_all("R13");
    step();

    // R2: field layout and readback
    wr(3, 5'd4, 2'd1, 2'd2, 2'd3, 2'd0);
    rd_check("R2", 3);
    wr(4, 5'd30, 2'd3, 2'd0, 2'd1, 2'd2);
    rd_check("R2", 4);

    // R3: out-of-range addresses
    wr(30, 5'd1, 2'd3, 2'd3, 2'd3, 2'd3);
    wr(31, 5'd2, 2'd1, 2'd1, 2'd1, 2'd1);
    rd_check("R3", 30);
    rd_check("R3", 31);
    for (int p = 0; p < NP; p++) rd_check("R3", p);

    // R4: normal routing, several patterns
    wr(3, 5'd0, 0, 0, 0, 0);
    wr(4, 5'd0, 0, 0, 0, 0);
    wr(0, 5'd0, 0, 0, 0, 0);
    wr(1, 5'd1, 0, 0, 0, 0);
    wr(9, 5'd2, 0, 0, 0, 0);
    wr(13, 5'd5, 0, 0, 0, 0);
    wr(29, 5'd9, 0, 0, 0, 0);
    wr(7, 5'd7, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      rand_inputs();
      expect_all("R4");
      step();
    end

    // R5: functions not selected have no effect
    fn_out = fn_out ^ {{(NF-4)*NS{1'b0}}, {NS{1'b1}}, {3*NS{1'b0}}};
    fn_oe  = fn_oe  ^ {{(NF-4)*NS{1'b0}}, {NS{1'b1}}, {3*NS{1'b0}}};
    expect_all("R5");
    step();

    // R6: null and unused codes
    wr(0, 5'h1F, 0, 0, 0, 0);
    wr(1, 5'd10, 0, 0, 0, 0);
    wr(9, 5'd30, 0, 0, 0, 0);
    wr(13, 5'd15, 0, 0, 0, 0);
    fn_out = '1; fn_oe = '1; pad_in = '1;
    expect_all("R6");
    step();

    // R7: partially available function at and around its range
    wr(19, 5'd8, 0, 0, 0, 0);
    wr(20, 5'd8, 0, 0, 0, 0);
    wr(25, 5'd8, 0, 0, 0, 0);
    wr(26, 5'd8, 0, 0, 0, 0);
    expect_all("R7");
    step();
    rand_inputs();
    expect_all("R7");
    step();

    // R8: output override
    wr(2, 5'd1, 2'd1, 0, 0, 0);
    wr(3, 5'd1, 2'd2, 0, 0, 0);
    wr(4, 5'h1F, 2'd3, 0, 0, 0);
    wr(5, 5'd4, 2'd3, 0, 0, 0);
    for (int k = 0; k < 2; k++) begin rand_inputs(); expect_all("R8"); step(); end

    // R9: enable override
    wr(2, 5'd1, 0, 2'd1, 0, 0);
    wr(3, 5'd1, 0, 2'd2, 0, 0);
    wr(4, 5'h1F, 0, 2'd3, 0, 0);
    wr(5, 5'd4, 0, 2'd0, 0, 0);
    for (int k = 0; k < 2; k++) begin rand_inputs(); expect_all("R9"); step(); end

    // R10: input override
    wr(10, 5'd6, 0, 0, 2'd1, 0);
    wr(11, 5'd6, 0, 0, 2'd2, 0);
    wr(12, 5'd6, 0, 0, 2'd3, 0);
    wr(15, 5'h1F, 0, 0, 2'd3, 0);
    for (int k = 0; k < 2; k++) begin rand_inputs(); expect_all("R10"); step(); end

    // R11: interrupt override
    wr(16, 5'd3, 0, 0, 0, 2'd0);
    wr(17, 5'd3, 0, 0, 0, 2'd1);
    wr(18, 5'h1F, 0, 0, 0, 2'd2);
    wr(19, 5'd12, 0, 0, 0, 2'd3);
    for (int k = 0; k < 2; k++) begin rand_inputs(); expect_all("R11"); step(); end

    // R12: four pins share slot 1 of function 2
    wr(1, 5'd2, 0, 0, 0, 0);
    wr(9, 5'd2, 0, 0, 0, 0);
    wr(17, 5'd2, 0, 0, 0, 0);
    wr(25, 5'd2, 0, 0, 0, 0);
    pad_in = '0;
    push("R12", 2, 2*NS + 1, 32'd0);
    expect_all("R12");
    step();
    pad_in = '0; pad_in[17] = 1'b1;
    push("R12", 2, 2*NS + 1, 32'd1);
    expect_all("R12");
    step();
    pad_in = '0; pad_in[1] = 1'b1; pad_in[25] = 1'b1;
    push("R12", 2, 2*NS + 1, 32'd1);
    expect_all("R12");
    step();
    wr(9, 5'd2, 0, 0, 2'd3, 0);
    pad_in = '0;
    push("R12", 2, 2*NS + 1, 32'd1);
    expect_all("R12");
    step();

    step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule